// File: doc/BRIEF.md
# Microcontroller Reset Sequencer

This block decides when a small 8-bit controller core is held in reset and when it is released. The active-low reset pin is sampled on the processor clock through a synchronizer. A low level is taken as a reset only if it lasts at least two clock cycles. While reset is recognized, the core is stalled and RUN is low, which is the static low-power condition. When the pin returns high, RUN rises and the bus control register is loaded from a bus-enable strap. A fixed-length vector-fetch sequence then runs, and a one-cycle strobe marks the fetch of the first opcode.

The reset pin is open-drain and bidirectional. A watchdog timeout pulse makes the block pull the pin low for a fixed number of cycles. That pulse is long enough to pass the same two-cycle qualification as an external reset, so the whole system restarts through the same path.

Top module: `rstseq_top`

## Requirements
- R1: While `rst` is high, `run`=0, `core_stall`=1, `first_fetch`=0, `resb_pull`=0 and `bus_ctrl`=0x00.
- R2: If the pin is sampled low on two consecutive rising edges E1 and E2, `run` is 0 and `core_stall` is 1 from the fourth edge after E1-1 (edge E1+3) onward.
- R3: A pin low that is sampled on only one rising edge is ignored. `run` stays 1 and `core_stall` stays 0.
- R4: While reset is recognized and the pin stays low, `run` stays 0. After the pin is first sampled high on edge F1, `run` rises at edge F1+2.
- R5: When `run` rises, `bus_ctrl` loads 0x89 if `bus_en_strap` was 0 and 0x00 if it was 1. At all other times `bus_ctrl` holds its value, whatever the strap does.
- R6: After `run` rises, `core_stall` stays 1 for exactly SEQ_LEN (default 9) cycles, then falls.
- R7: `first_fetch` is a single-cycle pulse in the first cycle with `core_stall`=0 after the sequence.
- R8: A `wdt_timeout` pulse sampled on an edge makes `resb_pull`=1 for the next PULL_CYCLES (default 3) cycles. This low pulse is then recognized as a reset, like R2 and R4.
- R9: A reset recognized during the vector sequence returns the block to the held state. The sequence restarts in full after release, and no `first_fetch` pulse comes from the aborted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| resb_in | input | 1 | Level seen on the reset pin (0 = reset) |
| resb_pull | output | 1 | Open-drain enable; 1 pulls the reset pin low |
| bus_en_strap | input | 1 | Bus-enable strap; selects the bus control reset value |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| run | output | 1 | 1 when the core is not held in reset |
| core_stall | output | 1 | 1 from reset recognition to the end of the vector sequence |
| bus_ctrl | output | 8 | Bus control register value |
| first_fetch | output | 1 | One-cycle strobe at the first opcode fetch |

## Verification
Every result has a fixed latency, counted from the edge that first samples a change on the pin:
- recognition shows three edges later;
- `run` rises two edges after the pin is first sampled high;
- `core_stall` falls, and `first_fetch` pulses, SEQ_LEN edges after that;
- `resb_pull` follows a timeout one edge later.

The stimulus tasks work out each due cycle from these counts and place expected items in a queue. A monitor then compares each item at the falling edge of exactly its due cycle. For "ignored" cases, expected steady values are queued across the whole window in which a wrong reaction would show.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        PH_HELD   = 2'd0,
        PH_VECTOR = 2'd1,
        PH_ACTIVE = 2'd2
    } phase_e;

    typedef struct packed {
        logic run;
        logic stall;
        logic fetch;
    } core_ctl_t;

    localparam logic [7:0] BCR_STRAP_LOW  = 8'h89;
    localparam logic [7:0] BCR_STRAP_HIGH = 8'h00;

    function automatic logic [7:0] bcr_init(input logic strap);
        return strap ? BCR_STRAP_HIGH : BCR_STRAP_LOW;
    endfunction

    function automatic core_ctl_t phase_ctl(input phase_e ph, input logic fetch);
        core_ctl_t c;
        c.run   = (ph != PH_HELD);
        c.stall = (ph != PH_ACTIVE);
        c.fetch = fetch;
        return c;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rstseq_qualify.sv
module rstseq_qualify #(
    parameter int HOLD_MIN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_sync,
    output logic held
);
    localparam int CW = $clog2(HOLD_MIN + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_MIN - 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
        end else if (pin_sync) begin
            low_cnt <= '0;
        end else if (low_cnt != LAST) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign held = !pin_sync && (low_cnt == LAST);
endmodule

// File: rtl/rstseq_wdt_pull.sv
module rstseq_wdt_pull #(
    parameter int PULL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic timeout,
    output logic pull
);
    localparam int CW = $clog2(PULL_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULL_CYCLES);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (timeout) begin
            left <= LOAD;
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign pull = (left != '0);
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int SEQ_LEN = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       held,
    input  logic       pin_sync,
    input  logic       strap,
    output core_ctl_t  ctl,
    output logic [7:0] bcr
);
    localparam int CW = $clog2(SEQ_LEN + 1);
    localparam logic [CW-1:0] SEQ_LAST = CW'(SEQ_LEN - 1);

    phase_e        phase;
    logic [CW-1:0] step;
    logic          fetch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_HELD;
            step    <= '0;
            bcr     <= 8'h00;
            fetch_q <= 1'b0;
        end else begin
            fetch_q <= 1'b0;
            unique case (phase)
                PH_ACTIVE: begin
                    if (held) phase <= PH_HELD;
                end
                PH_HELD: begin
                    if (pin_sync) begin
                        phase <= PH_VECTOR;
                        step  <= '0;
                        bcr   <= bcr_init(strap);
                    end
                end
                PH_VECTOR: begin
                    if (held) begin
                        phase <= PH_HELD;
                    end else if (step == SEQ_LAST) begin
                        phase   <= PH_ACTIVE;
                        fetch_q <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: phase <= PH_HELD;
            endcase
        end
    end

    assign ctl = phase_ctl(phase, fetch_q);
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_MIN    = 2,
    parameter int SEQ_LEN     = 9,
    parameter int PULL_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       resb_in,
    output logic       resb_pull,
    input  logic       bus_en_strap,
    input  logic       wdt_timeout,
    output logic       run,
    output logic       core_stall,
    output logic [7:0] bus_ctrl,
    output logic       first_fetch
);
    logic      pin_sync;
    logic      held;
    core_ctl_t ctl;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(resb_in), .dout(pin_sync)
    );

    rstseq_qualify #(.HOLD_MIN(HOLD_MIN)) u_qual (
        .clk(clk), .rst(rst), .pin_sync(pin_sync), .held(held)
    );

    rstseq_wdt_pull #(.PULL_CYCLES(PULL_CYCLES)) u_pull (
        .clk(clk), .rst(rst), .timeout(wdt_timeout), .pull(resb_pull)
    );

    rstseq_ctrl #(.SEQ_LEN(SEQ_LEN)) u_ctrl (
        .clk(clk), .rst(rst), .held(held), .pin_sync(pin_sync),
        .strap(bus_en_strap), .ctl(ctl), .bcr(bus_ctrl)
    );

    assign run         = ctl.run;
    assign core_stall  = ctl.stall;
    assign first_fetch = ctl.fetch;
endmodule

// File: rtl/rstseq_top_chk.sv
module rstseq_top_chk #(
    parameter int SEQ_LEN = 9
) (
    input logic       clk,
    input logic       rst,
    input logic       resb_pull,
    input logic       bus_en_strap,
    input logic       wdt_timeout,
    input logic       run,
    input logic       core_stall,
    input logic [7:0] bus_ctrl,
    input logic       first_fetch
);
    localparam int CW = $clog2(SEQ_LEN + 2) + 1;
    logic [CW-1:0] vec_cycles;

    always_ff @(posedge clk) begin
        if (rst)                    vec_cycles <= '0;
        else if (run && core_stall) vec_cycles <= vec_cycles + 1'b1;
        else                        vec_cycles <= '0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!run && core_stall && !first_fetch && !resb_pull && bus_ctrl == 8'h00));

    // R4
    release_enters_seq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> core_stall);

    // R5
    bcr_value_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> bus_ctrl == ($past(bus_en_strap) ? 8'h00 : 8'h89));

    // R5
    bcr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(run) |-> $stable(bus_ctrl));

    // R6
    seq_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_stall) |-> vec_cycles == CW'(SEQ_LEN));

    // R7
    fetch_single_chk: assert property (@(posedge clk) disable iff (rst)
        first_fetch |=> !first_fetch);

    // R7
    fetch_after_seq_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_stall) |-> first_fetch);

    // R8
    pull_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(resb_pull) |-> $past(wdt_timeout));
endmodule

bind rstseq_top rstseq_top_chk #(.SEQ_LEN(SEQ_LEN)) u_chk (
    .clk(clk), .rst(rst), .resb_pull(resb_pull), .bus_en_strap(bus_en_strap),
    .wdt_timeout(wdt_timeout), .run(run), .core_stall(core_stall),
    .bus_ctrl(bus_ctrl), .first_fetch(first_fetch)
);

// File: tb/rstseq_top_test.sv
`timescale 1ns/1ps
module rstseq_top_test;
    localparam int SEQ  = 9;
    localparam int PULL = 3;
    localparam int K_RUN = 0, K_STALL = 1, K_BCR = 2, K_FETCH = 3, K_PULL = 4;

    typedef struct {
        int         due;
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_low = 1'b0;
    logic strap = 1'b0;
    logic wdt = 1'b0;
    logic resb_pull, run, core_stall, first_fetch;
    logic [7:0] bus_ctrl;
    logic pin;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 0;
    item_t sb[$];

    assign pin = !(ext_low || resb_pull);

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rstseq_top #(.SEQ_LEN(SEQ), .PULL_CYCLES(PULL)) uut (
        .clk(clk), .rst(rst), .resb_in(pin), .resb_pull(resb_pull),
        .bus_en_strap(strap), .wdt_timeout(wdt), .run(run),
        .core_stall(core_stall), .bus_ctrl(bus_ctrl), .first_fetch(first_fetch)
    );

    task automatic expect_at(input int due, input int kind, input logic [7:0] exp,
                             input string req);
        item_t it;
        int pos;
        it.due = due; it.kind = kind; it.exp = exp; it.req = req;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].due > due) begin pos = i; break; end
        end
        sb.insert(pos, it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pin first sampled high on edge m+1: run rises at m+3, sequence ends at m+12.
    task automatic exp_release(input int m, input logic s);
        expect_at(m + 2, K_RUN, 8'd0, "R4");
        expect_at(m + 3, K_RUN, 8'd1, "R4");
        expect_at(m + 3, K_STALL, 8'd1, "R6");
        expect_at(m + 3, K_BCR, s ? 8'h00 : 8'h89, "R5");
        expect_at(m + 3 + SEQ - 1, K_STALL, 8'd1, "R6");
        expect_at(m + 3 + SEQ - 1, K_FETCH, 8'd0, "R7");
        expect_at(m + 3 + SEQ, K_STALL, 8'd0, "R6");
        expect_at(m + 3 + SEQ, K_FETCH, 8'd1, "R7");
        expect_at(m + 4 + SEQ, K_FETCH, 8'd0, "R7");
    endtask

    // monitor
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [7:0] obs;
            it = sb.pop_front();
            case (it.kind)
                K_RUN:   obs = {7'd0, run};
                K_STALL: obs = {7'd0, core_stall};
                K_BCR:   obs = bus_ctrl;
                K_FETCH: obs = {7'd0, first_fetch};
                default: obs = {7'd0, resb_pull};
            endcase
            checks++;
            if (obs !== it.exp || it.due != cyc) begin
                failures++;
                $display("FAIL %s kind=%0d cycle=%0d actual=%0h expected=%0h",
                         it.req, it.kind, cyc, obs, it.exp);
            end
        end
    end

    initial begin
        int n, m, w;
        tick(2);
        // R1 reset state
        expect_at(cyc + 1, K_RUN, 8'd0, "R1");
        expect_at(cyc + 1, K_STALL, 8'd1, "R1");
        expect_at(cyc + 1, K_BCR, 8'h00, "R1");
        expect_at(cyc + 1, K_FETCH, 8'd0, "R1");
        expect_at(cyc + 1, K_PULL, 8'd0, "R1");
        tick(2);
        m = cyc;
        rst = 1'b0;
        exp_release(m, 1'b0);
        tick(SEQ + 8);

        // R3 one-cycle low ignored
        n = cyc;
        ext_low = 1'b1;
        tick(1);
        ext_low = 1'b0;
        for (int k = 3; k <= 7; k++) begin
            expect_at(n + k, K_RUN, 8'd1, "R3");
            expect_at(n + k, K_STALL, 8'd0, "R3");
        end
        tick(10);

        // R2 / R4 / R5 external reset with strap high
        strap = 1'b1;
        tick(1);
        n = cyc;
        ext_low = 1'b1;
        expect_at(n + 3, K_RUN, 8'd1, "R2");
        expect_at(n + 4, K_RUN, 8'd0, "R2");
        expect_at(n + 4, K_STALL, 8'd1, "R2");
        expect_at(n + 6, K_RUN, 8'd0, "R4");
        tick(6);
        m = cyc;
        ext_low = 1'b0;
        exp_release(m, 1'b1);
        tick(SEQ + 8);

        // R5 strap change outside release has no effect
        strap = 1'b0;
        tick(3);
        expect_at(cyc + 1, K_BCR, 8'h00, "R5");
        expect_at(cyc + 1, K_RUN, 8'd1, "R5");
        tick(3);

        // R8 watchdog pull-low and restart
        w = cyc;
        wdt = 1'b1;
        tick(1);
        wdt = 1'b0;
        for (int k = 1; k <= PULL; k++) expect_at(w + k, K_PULL, 8'd1, "R8");
        expect_at(w + PULL + 1, K_PULL, 8'd0, "R8");
        expect_at(w + 5, K_RUN, 8'd0, "R8");
        exp_release(w + PULL + 1, 1'b0);
        tick(PULL + SEQ + 10);

        // R9 reset recognized during the vector sequence
        n = cyc;
        ext_low = 1'b1;
        tick(5);
        m = cyc;
        ext_low = 1'b0;
        expect_at(m + 3, K_RUN, 8'd1, "R9");
        expect_at(m + 3, K_STALL, 8'd1, "R9");
        tick(5);
        n = cyc;
        ext_low = 1'b1;
        tick(2);
        ext_low = 1'b0;
        expect_at(n + 4, K_RUN, 8'd0, "R9");
        expect_at(m + 12, K_FETCH, 8'd0, "R9");
        expect_at(m + 12, K_STALL, 8'd1, "R9");
        exp_release(n + 2, 1'b0);
        tick(SEQ + 10);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule